// File: doc/BRIEF.md
# LPI highest-priority pending scanner

This block finds the best pending message-signalled interrupt for one redistributor. It does this by walking two tables in system memory. One is a pending bitmap with one bit per interrupt ID. The other is a configuration table with one byte per interrupt ID. On a start pulse the scanner fetches the pending bitmap one byte at a time, in ascending ID order. For every pending ID it fetches the configuration byte and derives a priority from it. It keeps the best enabled candidate seen so far. When the walk ends, it publishes that candidate as the cached best interrupt, together with its priority and group.

The control unit is a single state machine with six states:
- `S_IDLE` waits for a start pulse and then moves to `S_CHECK`.
- `S_CHECK` snapshots the inputs and checks them. If the scan may run, it clears the working candidate and goes to `S_PEND_RD`. Otherwise it goes straight to `S_DONE`.
- `S_PEND_RD` holds a read request for one pending byte and moves to `S_BITS` on grant.
- `S_BITS` picks the lowest pending bit that has not yet been evaluated and goes to `S_CFG_RD`. When no bits remain, it moves on to the next byte through `S_PEND_RD`. After the last byte it goes to `S_DONE` and publishes the result.
- `S_CFG_RD` holds a read of one configuration byte, evaluates it on grant, and returns to `S_BITS`.
- `S_DONE` raises the done pulse. It then restarts through `S_CHECK` if a start is pending, or returns to `S_IDLE`.

Top module: `lpi_hpp_scanner`

## Requirements
- R1: After reset the outputs read as follows: `best_valid`=0, `best_prio`=0xFF, `best_id`=0, `best_grp`=0, `done`=0 and `mem_req`=0.
- R2: A read request holds `mem_req` high with `mem_addr` unchanged until `mem_gnt`. `mem_rdata` is taken in the cycle of the grant, and any number of stall cycles gives the same result.
- R3: Interrupt ID N is pending when bit (N mod 8) of the byte at `pend_base` + N/8 is set. Its configuration byte is at `cfg_base` + (N − 8192). One scan reads every pending byte of the range exactly once. It reads one configuration byte per pending ID in range, and nothing else.
- R4: Bit 0 of the configuration byte is an enable. A pending ID whose enable is clear is never chosen.
- R5: The raw priority is the configuration byte ANDed with 0xFC. With `sec_dis`=1 the raw priority is used as it is. With `sec_dis`=0 the priority is (raw >> 1) | 0x80. Bit 0 of a reported priority is therefore always 0.
- R6: A lower priority value wins. On equal priority the lower ID wins.
- R7: Every scan that runs starts from "no candidate" (0xFF). If it finds no candidate, it publishes `best_valid`=0, `best_prio`=0xFF, `best_id`=0 and `best_grp`=0.
- R8: The scan covers IDs 8192 to 2^(k+1)−1, where k is the smaller of `idbits` and the build-time maximum (13 by default, which gives 1024 pending bytes).
- R9: A scan is skipped when `lpi_en`=0, when either base is zero, or when k < 13. A skipped scan makes no memory reads, leaves all result outputs unchanged, and still gives one `done` pulse.
- R10: A valid result always reports group 2'b10 (non-secure group 1) and an ID of at least 8192.
- R11: `done` is a single-cycle pulse at the end of each scan. The result outputs change only in a cycle where `done` is high.
- R12: Start pulses that arrive while a scan is running collapse into one pending request. That request starts a single further scan once the current one ends.
- R13: The bases, `idbits`, `lpi_en` and `sec_dis` are sampled once, in the cycle after the start is taken. Changes to them later in the scan have no effect on that scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle scan request |
| lpi_en | input | 1 | Message-signalled interrupt enable |
| sec_dis | input | 1 | Security-disable flag that selects the priority mapping |
| cfg_base | input | ADDR_W | Configuration table base address |
| pend_base | input | ADDR_W | Pending bitmap base address |
| idbits | input | IDB_W | Programmed ID-bits field |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_gnt | input | 1 | Read grant; data is valid in the same cycle |
| mem_rdata | input | 8 | Read data byte |
| best_id | output | MAX_IDBITS+1 | Published best interrupt ID |
| best_prio | output | 8 | Published best priority (0xFF when none) |
| best_grp | output | 2 | Published group (2'b10 when valid) |
| best_valid | output | 1 | A candidate was found |
| done | output | 1 | Scan-complete pulse |

## Verification
The assertions assume that `mem_gnt` is raised only while `mem_req` is high, and that `mem_rdata` is valid in the grant cycle. They also assume reset is applied before the first scan. The bench memory model derives the grant from the request, optionally gated by a free-running LFSR to insert stalls. It decodes the address into a pending region and a configuration region. The bench changes every input only on the falling clock edge. Because of this, the inputs the scanner samples are always settled.

// File: rtl/lpi_scan_pkg.sv
package lpi_scan_pkg;

    // First interrupt ID handled by the scanner
    localparam int unsigned LPI_FIRST_ID  = 8192;
    // Smallest effective ID-bits value whose range reaches LPI_FIRST_ID
    localparam int unsigned MIN_SPAN_BITS = 13;
    // Priority value meaning "no candidate"
    localparam logic [7:0]  PRIO_NONE     = 8'hFF;
    // Priority field of a configuration byte
    localparam logic [7:0]  PRIO_FIELD    = 8'hFC;

    typedef enum logic [1:0] {
        GRP_SEC0 = 2'd0,
        GRP_SEC1 = 2'd1,
        GRP_NS1  = 2'd2
    } irq_grp_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_PEND_RD,
        S_BITS,
        S_CFG_RD,
        S_DONE
    } scan_state_e;

    // Index of the lowest set bit of a byte (0 if none)
    function automatic logic [2:0] lowest_set(input logic [7:0] v);
        logic [2:0] r;
        r = 3'd0;
        for (int i = 7; i >= 0; i--) begin
            if (v[i]) r = 3'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/lpi_cfg_decode.sv
module lpi_cfg_decode
    import lpi_scan_pkg::*;
(
    input  logic [7:0] cfg_byte,
    input  logic       sec_dis,
    output logic       enabled,
    output logic [7:0] prio
);

    logic [7:0] raw;

    always_comb begin
        raw     = cfg_byte & PRIO_FIELD;
        enabled = cfg_byte[0];
        if (sec_dis) begin
            prio = raw;
        end else begin
            prio = (raw >> 1) | 8'h80;
        end
    end

endmodule

// File: rtl/lpi_best_track.sv
module lpi_best_track
    import lpi_scan_pkg::*;
#(
    parameter int ID_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            cand_vld,
    input  logic [ID_W-1:0] cand_id,
    input  logic [7:0]      cand_prio,
    output logic [ID_W-1:0] work_id,
    output logic [7:0]      work_prio
);

    logic better;

    always_comb begin
        better = (cand_prio < work_prio) ||
                 ((cand_prio == work_prio) && (cand_id < work_id));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_prio <= PRIO_NONE;
            work_id   <= '1;
        end else if (clear) begin
            work_prio <= PRIO_NONE;
            work_id   <= '1;
        end else if (cand_vld && better) begin
            work_prio <= cand_prio;
            work_id   <= cand_id;
        end
    end

endmodule

// File: rtl/lpi_scan_fsm.sv
module lpi_scan_fsm
    import lpi_scan_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int IDB_W      = 5,
    parameter  int MAX_IDBITS = 13,
    localparam int ID_W       = MAX_IDBITS + 1,
    localparam int BYTE_W     = ID_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              lpi_en,
    input  logic              sec_dis,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] pend_base,
    input  logic [IDB_W-1:0]  idbits,
    input  logic              mem_gnt,
    input  logic [7:0]        mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              track_clear,
    output logic              eval_stb,
    output logic [ID_W-1:0]   cand_id,
    output logic              sec_dis_q,
    output logic              publish,
    output logic              done
);

    localparam logic [BYTE_W-1:0] FIRST_BYTE = BYTE_W'(LPI_FIRST_ID / 8);
    localparam logic [ID_W-1:0]   FIRST_ID   = ID_W'(LPI_FIRST_ID);

    scan_state_e state_q, state_d;

    logic [ADDR_W-1:0] cfg_base_q, pend_base_q;
    logic [BYTE_W-1:0] byte_q, last_byte_q;
    logic [7:0]        mask_q;
    logic [2:0]        bit_q;
    logic              again_q;

    // Input qualification, used only in S_CHECK
    logic [IDB_W-1:0]  eff_bits;
    logic [BYTE_W:0]   span_bytes;
    logic [BYTE_W-1:0] last_calc;
    logic              gate_ok;
    logic              mask_empty, at_last;

    always_comb begin
        eff_bits   = (idbits > IDB_W'(MAX_IDBITS)) ? IDB_W'(MAX_IDBITS) : idbits;
        span_bytes = (BYTE_W+1)'(1) << (eff_bits - IDB_W'(2));
        last_calc  = BYTE_W'(span_bytes - (BYTE_W+1)'(1));
        gate_ok    = lpi_en && (|cfg_base) && (|pend_base) &&
                     (eff_bits >= IDB_W'(MIN_SPAN_BITS));
        mask_empty = (mask_q == 8'h00);
        at_last    = (byte_q == last_byte_q);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_CHECK;
            S_CHECK:   state_d = gate_ok ? S_PEND_RD : S_DONE;
            S_PEND_RD: if (mem_gnt) state_d = S_BITS;
            S_BITS: begin
                if (!mask_empty)  state_d = S_CFG_RD;
                else if (at_last) state_d = S_DONE;
                else              state_d = S_PEND_RD;
            end
            S_CFG_RD:  if (mem_gnt) state_d = S_BITS;
            S_DONE:    state_d = (again_q || start) ? S_CHECK : S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_base_q  <= '0;
            pend_base_q <= '0;
            sec_dis_q   <= 1'b0;
            last_byte_q <= '0;
            byte_q      <= '0;
            mask_q      <= '0;
            bit_q       <= '0;
        end else begin
            unique case (state_q)
                S_CHECK: begin
                    cfg_base_q  <= cfg_base;
                    pend_base_q <= pend_base;
                    sec_dis_q   <= sec_dis;
                    last_byte_q <= last_calc;
                    byte_q      <= FIRST_BYTE;
                    mask_q      <= '0;
                end
                S_PEND_RD: if (mem_gnt) mask_q <= mem_rdata;
                S_BITS: begin
                    if (!mask_empty)  bit_q  <= lowest_set(mask_q);
                    else if (!at_last) byte_q <= byte_q + BYTE_W'(1);
                end
                S_CFG_RD:  if (mem_gnt) mask_q[bit_q] <= 1'b0;
                default: ;
            endcase
        end
    end

    // Restart latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            again_q <= 1'b0;
        end else if (state_q == S_DONE) begin
            again_q <= 1'b0;
        end else if (start && (state_q != S_IDLE)) begin
            again_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        cand_id     = {byte_q, bit_q};
        mem_req     = 1'b0;
        mem_addr    = '0;
        track_clear = 1'b0;
        eval_stb    = 1'b0;
        publish     = 1'b0;
        done        = 1'b0;
        unique case (state_q)
            S_CHECK:   track_clear = gate_ok;
            S_PEND_RD: begin
                mem_req  = 1'b1;
                mem_addr = pend_base_q + ADDR_W'(byte_q);
            end
            S_BITS:    publish = mask_empty && at_last;
            S_CFG_RD: begin
                mem_req  = 1'b1;
                mem_addr = cfg_base_q + ADDR_W'(cand_id - FIRST_ID);
                eval_stb = mem_gnt;
            end
            S_DONE:    done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/lpi_hpp_scanner.sv
module lpi_hpp_scanner
    import lpi_scan_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int IDB_W      = 5,
    parameter  int MAX_IDBITS = 13,
    localparam int ID_W       = MAX_IDBITS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              lpi_en,
    input  logic              sec_dis,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] pend_base,
    input  logic [IDB_W-1:0]  idbits,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic [7:0]        mem_rdata,
    output logic [ID_W-1:0]   best_id,
    output logic [7:0]        best_prio,
    output logic [1:0]        best_grp,
    output logic              best_valid,
    output logic              done
);

    logic            track_clear, eval_stb, sec_dis_q, publish;
    logic [ID_W-1:0] cand_id, work_id;
    logic            cfg_en, cand_vld;
    logic [7:0]      cfg_prio, work_prio;

    lpi_scan_fsm #(
        .ADDR_W     (ADDR_W),
        .IDB_W      (IDB_W),
        .MAX_IDBITS (MAX_IDBITS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .lpi_en      (lpi_en),
        .sec_dis     (sec_dis),
        .cfg_base    (cfg_base),
        .pend_base   (pend_base),
        .idbits      (idbits),
        .mem_gnt     (mem_gnt),
        .mem_rdata   (mem_rdata),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .track_clear (track_clear),
        .eval_stb    (eval_stb),
        .cand_id     (cand_id),
        .sec_dis_q   (sec_dis_q),
        .publish     (publish),
        .done        (done)
    );

    lpi_cfg_decode u_dec (
        .cfg_byte (mem_rdata),
        .sec_dis  (sec_dis_q),
        .enabled  (cfg_en),
        .prio     (cfg_prio)
    );

    assign cand_vld = eval_stb && cfg_en;

    lpi_best_track #(.ID_W(ID_W)) u_best (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (track_clear),
        .cand_vld  (cand_vld),
        .cand_id   (cand_id),
        .cand_prio (cfg_prio),
        .work_id   (work_id),
        .work_prio (work_prio)
    );

    // Published result, refreshed only when a full scan completes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_valid <= 1'b0;
            best_prio  <= PRIO_NONE;
            best_id    <= '0;
            best_grp   <= GRP_SEC0;
        end else if (publish) begin
            best_valid <= (work_prio != PRIO_NONE);
            best_prio  <= work_prio;
            best_id    <= (work_prio != PRIO_NONE) ? work_id : '0;
            best_grp   <= (work_prio != PRIO_NONE) ? GRP_NS1 : GRP_SEC0;
        end
    end

endmodule

// File: rtl/lpi_hpp_scanner_chk.sv
module lpi_hpp_scanner_chk #(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ID_W-1:0]   best_id,
    input logic [7:0]        best_prio,
    input logic [1:0]        best_grp,
    input logic              best_valid,
    input logic              done
);

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    p_prio_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        best_valid |-> !best_prio[0]);

    p_grp_id_r10: assert property (@(posedge clk) disable iff (!rst_n)
        best_valid |-> ((best_grp == 2'b10) && (best_id >= ID_W'(8192))));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(best_prio) && $stable(best_id) &&
                   $stable(best_valid) && $stable(best_grp)));

    p_no_read_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

endmodule

bind lpi_hpp_scanner lpi_hpp_scanner_chk #(
    .ADDR_W (ADDR_W),
    .ID_W   (ID_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_gnt    (mem_gnt),
    .mem_addr   (mem_addr),
    .best_id    (best_id),
    .best_prio  (best_prio),
    .best_grp   (best_grp),
    .best_valid (best_valid),
    .done       (done)
);

// File: tb/tb_lpi_hpp_scanner.sv
module tb_lpi_hpp_scanner;

    localparam logic [31:0] PB = 32'h0001_0000;
    localparam logic [31:0] CB = 32'h0002_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        lpi_en = 1'b1;
    logic        sec_dis = 1'b1;
    logic [31:0] cfg_base = CB;
    logic [31:0] pend_base = PB;
    logic [4:0]  idbits = 5'd13;
    logic        mem_req, mem_gnt;
    logic [31:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [13:0] best_id;
    logic [7:0]  best_prio;
    logic [1:0]  best_grp;
    logic        best_valid, done;

    logic [7:0]  pend_mem [0:2047];
    logic [7:0]  cfg_mem  [0:8191];
    logic [15:0] lfsr = 16'hACE1;
    logic        stall_en = 1'b0;

    int nchk = 0, nerr = 0;
    int pend_rd_cnt = 0, cfg_rd_cnt = 0, other_rd_cnt = 0, done_cnt = 0;
    bit finished = 0;

    logic [13:0] prev_id = '0;
    logic [7:0]  prev_prio = 8'hFF;
    logic        prev_valid = 1'b0;

    always #10 clk = ~clk;

    lpi_hpp_scanner dut (
        .clk(clk), .rst_n(rst_n), .start(start), .lpi_en(lpi_en),
        .sec_dis(sec_dis), .cfg_base(cfg_base), .pend_base(pend_base),
        .idbits(idbits), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .best_id(best_id),
        .best_prio(best_prio), .best_grp(best_grp), .best_valid(best_valid),
        .done(done)
    );

    assign mem_gnt = mem_req && (!stall_en || lfsr[0]);

    always_comb begin
        mem_rdata = 8'h00;
        if (mem_addr >= PB && mem_addr < PB + 32'd2048)
            mem_rdata = pend_mem[11'(mem_addr - PB)];
        else if (mem_addr >= CB && mem_addr < CB + 32'd8192)
            mem_rdata = cfg_mem[13'(mem_addr - CB)];
    end

    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (done) done_cnt <= done_cnt + 1;
        if (mem_req && mem_gnt) begin
            if (mem_addr >= PB && mem_addr < PB + 32'd2048) pend_rd_cnt <= pend_rd_cnt + 1;
            else if (mem_addr >= CB && mem_addr < CB + 32'd8192) cfg_rd_cnt <= cfg_rd_cnt + 1;
            else other_rd_cnt <= other_rd_cnt + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference selection computed from the requirement text
    task automatic model(input int idb, input bit sd, output logic [13:0] eid,
                         output logic [7:0] ep, output bit ev, output int np);
        int eff, top;
        logic [7:0] c, p;
        eff = (idb > 13) ? 13 : idb;
        top = 1 << (eff + 1);
        eid = '0; ep = 8'hFF; ev = 0; np = 0;
        for (int id = 8192; id < top; id++) begin
            if (pend_mem[11'(id >> 3)][3'(id & 7)]) begin
                np++;
                c = cfg_mem[13'(id - 8192)];
                if (c[0]) begin
                    p = sd ? (c & 8'hFC) : (((c & 8'hFC) >> 1) | 8'h80);
                    if (p < ep) begin ep = p; eid = 14'(id); ev = 1; end
                end
            end
        end
    endtask

    task automatic clear_tables();
        for (int i = 0; i < 2048; i++) pend_mem[i] = (i < 1024) ? 8'hFF : 8'h00;
        for (int i = 0; i < 8192; i++) cfg_mem[i] = 8'h00;
    endtask

    task automatic set_lpi(input int id, input logic [7:0] cfg);
        pend_mem[11'(id >> 3)][3'(id & 7)] = 1'b1;
        cfg_mem[13'(id - 8192)] = cfg;
    endtask

    task automatic check_result(input string req, input bit run, input int idb, input bit sd,
                                input int p0, input int c0);
        logic [13:0] eid; logic [7:0] ep; bit ev; int np;
        if (run) begin
            model(idb, sd, eid, ep, ev, np);
            prev_id = eid; prev_prio = ep; prev_valid = ev;
            chk(req, "pending bytes read (R3)", 32'(pend_rd_cnt - p0), 32'd1024);
            chk(req, "config bytes read (R3)", 32'(cfg_rd_cnt - c0), 32'(np));
        end else begin
            chk("R9", "reads on skipped scan", 32'(pend_rd_cnt - p0 + cfg_rd_cnt - c0), 32'd0);
        end
        chk(req, "best_id", 32'(best_id), 32'(prev_id));
        chk(req, "best_prio", 32'(best_prio), 32'(prev_prio));
        chk(req, "best_valid", 32'(best_valid), 32'(prev_valid));
        chk("R10", "best_grp", 32'(best_grp), prev_valid ? 32'd2 : 32'd0);
    endtask

    task automatic run_scan(input string req, input bit run, input bit perturb);
        int idb_s, p0, c0, waited;
        bit sd_s, stable_ok;
        idb_s = int'(idbits); sd_s = sec_dis;
        p0 = pend_rd_cnt; c0 = cfg_rd_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (perturb) begin
            @(negedge clk);
            sec_dis = ~sec_dis; idbits = 5'd0; lpi_en = 1'b0;
        end
        waited = 0; stable_ok = 1;
        while (!done && waited < 40000) begin
            if (best_id !== prev_id || best_prio !== prev_prio || best_valid !== prev_valid)
                stable_ok = 0;
            @(negedge clk);
            waited++;
        end
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL R11 scan end: got done=0 expected done=1");
        end else begin
            check_result(req, run, idb_s, sd_s, p0, c0);
            chk("R11", "outputs stable mid-scan", 32'(stable_ok), 32'd1);
            @(negedge clk);
            chk("R11", "done single pulse", 32'(done), 32'd0);
        end
        if (perturb) begin
            sec_dis = sd_s; idbits = 5'(idb_s); lpi_en = 1'b1;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL R11 watchdog: got hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int base;
        clear_tables();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "valid", 32'(best_valid), 32'd0);
        chk("R1", "prio", 32'(best_prio), 32'hFF);
        chk("R1", "id", 32'(best_id), 32'd0);
        chk("R1", "grp", 32'(best_grp), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "mem_req", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: empty tables, no candidate
        run_scan("R7", 1, 0);
        // R3/R5: single lowest ID, direct priority
        set_lpi(8192, 8'h43);
        run_scan("R3", 1, 0);
        chk("R5", "direct priority value", 32'(best_prio), 32'h40);
        // R5: remapped priority
        sec_dis = 1'b0;
        run_scan("R5", 1, 0);
        chk("R5", "remapped priority value", 32'(best_prio), 32'hA0);
        sec_dis = 1'b1;
        // R6: tie goes to lower ID
        clear_tables();
        set_lpi(9000, 8'h85);
        set_lpi(12000, 8'h81);
        set_lpi(10000, 8'h81);
        run_scan("R6", 1, 0);
        chk("R6", "tie winner", 32'(best_id), 32'd10000);
        // R4: disabled entry with best priority is skipped; enabled but not pending ignored
        clear_tables();
        set_lpi(8200, 8'h00);
        set_lpi(15000, 8'hF1);
        cfg_mem[13'(8300 - 8192)] = 8'h05;
        run_scan("R4", 1, 0);
        chk("R4", "disabled skipped", 32'(best_id), 32'd15000);
        // R8: field above the maximum is clamped, top ID reachable
        set_lpi(16383, 8'h09);
        idbits = 5'd20;
        run_scan("R8", 1, 0);
        chk("R8", "top ID selected", 32'(best_id), 32'd16383);
        idbits = 5'd13;
        // R9: each skip condition keeps the prior valid result
        lpi_en = 1'b0;     run_scan("R9", 0, 0); lpi_en = 1'b1;
        cfg_base = '0;     run_scan("R9", 0, 0); cfg_base = CB;
        pend_base = '0;    run_scan("R9", 0, 0); pend_base = PB;
        idbits = 5'd12;    run_scan("R9", 0, 0); idbits = 5'd13;
        // R7: a new scan starts from no candidate
        clear_tables();
        run_scan("R7", 1, 0);
        // R13: inputs changed after sampling have no effect
        set_lpi(11111, 8'h31);
        set_lpi(9999, 8'h35);
        run_scan("R13", 1, 1);
        chk("R13", "sampled inputs used", 32'(best_id), 32'd11111);
        // R12: several starts during a scan give exactly one more scan
        base = done_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (100) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        @(negedge clk) start = 1'b0;
        repeat (6000) @(negedge clk);
        chk("R12", "done pulses", 32'(done_cnt - base), 32'd2);
        chk("R12", "result after restart", 32'(best_id), 32'd11111);
        // R5 sweep over configuration byte values under both mappings
        for (int sd = 0; sd < 2; sd++) begin
            for (int k = 0; k < 12; k++) begin
                clear_tables();
                set_lpi(9000, 8'((k * 23) | 1));
                sec_dis = sd[0];
                run_scan("R5", 1, 0);
            end
        end
        // R2/R6: random dense tables with and without grant stalls
        for (int r = 0; r < 6; r++) begin
            for (int i = 1024; i < 2048; i++) pend_mem[i] = 8'($urandom & $urandom & $urandom);
            for (int i = 0; i < 8192; i++) cfg_mem[i] = 8'($urandom);
            sec_dis = r[0];
            stall_en = r[1];
            run_scan("R2", 1, 0);
        end
        chk("R3", "reads outside tables", 32'(other_rd_cnt), 32'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule